// File: doc/BRIEF.md
# Framed Serial Link Transmitter

This block turns a 10-bit parallel word into a framed bit stream. A separate receiver can rebuild both the bit clock and the word boundaries from that stream. One word arrives per reference-clock period, and a configuration pin selects which reference edge captures it. The block runs from a bit-rate clock `clk_i` and sees the reference clock as a slow level input with a period of exactly one frame (12 bit times). The bit clock therefore acts as a 12x enable tied to the word clock. The clock multiplier itself is outside the block, and `lock_i` reports its status.

Each frame carries a leading one, the data bits, and a trailing zero, so a receiver can regain alignment at any time, for instance after hot insertion. After lock is gained, or after power-down is released, the block first sends a training pattern for a minimum number of frames. It keeps sending that pattern while either of two request pins is high. Every change of mode takes effect on a frame boundary. While lock is absent or power-down is asserted, the pad-driver enable is low, so the line is in high impedance.

Top module: `framed_serial_tx`

## Requirements
- R1: While `rst_ni` is low, `oe_o` and `bit_o` are 0.
- R2: When `edge_sel_i` is 0, the word is captured on the rising edge of `ref_clk_i`. When it is 1, the word is captured on the falling edge.
- R3: A data frame is 12 bit times long. Bit time 0 carries a 1. Bit times 1 to 10 carry the captured word, least significant bit first. Bit time 11 carries a 0.
- R4: A training frame sends 1 in bit times 0 to 5 and 0 in bit times 6 to 11. Read with bit time i at bit position i, this is the value 0x03F.
- R5: Once `lock_i` is high and `pwrdn_i` is low, training starts at the next frame boundary and lasts exactly MIN_SYNC_FRAMES frames (default 1024) when no request is present. The data frames follow directly after.
- R6: While `sync_a_i` or `sync_b_i` is high, training continues past the minimum. The first data frame starts at the frame boundary where both requests are seen low.
- R7: While `lock_i` is low, `oe_o` is 0 and `bit_o` is 0. When lock returns, the full minimum training is sent again.
- R8: Asserting `pwrdn_i` drops `oe_o` in the same cycle and aborts the frame in progress. When power-down is released, training restarts with the full minimum.
- R9: The word captured during one frame period is the data sent in the next frame. Modes switch only at frame boundaries, so no partial frame is ever sent.
- R10: A request raised while data is being sent starts training at the next boundary, with no minimum count. Data resumes at the first boundary where both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Word reference clock, one period per frame |
| edge_sel_i | input | 1 | Capture edge: 0 rising, 1 falling |
| data_i | input | DATA_W | Parallel word |
| pwrdn_i | input | 1 | Power-down request |
| sync_a_i | input | 1 | Training request A |
| sync_b_i | input | 1 | Training request B |
| lock_i | input | 1 | Clock multiplier locked |
| bit_o | output | 1 | Serial bit, 0 while disabled |
| oe_o | output | 1 | Line driver enable; low means high impedance |

## Verification
The assertions take for granted that `ref_clk_i` is a clean level signal with exactly one rising and one falling edge per 12 bit-clock cycles, phase-aligned to the internal frame counter. They also assume that `data_i` is stable on the bit-clock edge that sees the selected reference edge. The stimulus generates the reference clock from the same frame phase it tracks. It changes the data away from both capture edges and changes the mode pins only just before a frame boundary. The one exception is a single mid-frame power-down, which exercises the immediate drop of the enable.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } tx_mode_e;
endpackage

// File: rtl/ftx_capture.sv
module ftx_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              edge_sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] word_o
);
  logic ref_q;
  logic rise, fall, strobe;
  logic [DATA_W-1:0] hold_q;

  assign rise   = ref_clk_i & ~ref_q;
  assign fall   = ~ref_clk_i & ref_q;
  assign strobe = edge_sel_i ? fall : rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      ref_q <= ref_clk_i;
      if (strobe) hold_q <= data_i;
    end
  end

  assign word_o = hold_q;
endmodule

// File: rtl/ftx_ctrl.sv
module ftx_ctrl
  import ftx_pkg::*;
#(
  parameter int FRAME_BITS      = 12,
  parameter int MIN_SYNC_FRAMES = 1024,
  localparam int CW = $clog2(FRAME_BITS),
  localparam int SW = $clog2(MIN_SYNC_FRAMES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          pwrdn_i,
  input  logic          sync_req_i,
  output tx_mode_e      mode_o,
  output tx_mode_e      mode_d_o,
  output logic          at_last_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);
  localparam logic [SW-1:0] SMAX = SW'(MIN_SYNC_FRAMES - 1);

  tx_mode_e      st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          at_last, live;

  assign at_last = (cnt_q == LAST);
  assign live    = lock_i & ~pwrdn_i;

  always_comb begin
    st_d   = st_q;
    scnt_d = scnt_q;
    if (!live) begin
      st_d   = ST_OFF;
      scnt_d = '0;
    end else if (at_last) begin
      unique case (st_q)
        ST_OFF: begin
          st_d   = ST_SYNC;
          scnt_d = '0;
        end
        ST_SYNC: begin
          if (scnt_q == SMAX && !sync_req_i) st_d = ST_DATA;
          else if (scnt_q != SMAX)            scnt_d = scnt_q + 1'b1;
        end
        ST_DATA: begin
          if (sync_req_i) begin
            st_d   = ST_SYNC;
            scnt_d = SMAX;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      scnt_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      scnt_q <= scnt_d;
      cnt_q  <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

  assign mode_o    = st_q;
  assign mode_d_o  = st_d;
  assign at_last_o = at_last;
  assign cnt_o     = cnt_q;

  AST_OFF_ON_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> st_q == ST_OFF); // R7
  AST_OFF_ON_PWRDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |=> st_q == ST_OFF); // R8
  AST_MODE_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != $past(st_q)) && (st_q != ST_OFF) |-> $past(cnt_q) == LAST); // R9
  AST_SYNC_MINIMUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA) && ($past(st_q) == ST_SYNC) |-> $past(scnt_q) == SMAX); // R5
  AST_REQ_HOLDS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_last && (st_q == ST_SYNC) && sync_req_i && live |=> st_q == ST_SYNC); // R6
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter
  import ftx_pkg::*;
#(
  parameter int DATA_W = 10,
  localparam int FRAME_BITS = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              at_last_i,
  input  tx_mode_e          mode_d_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              bit_o
);
  localparam int ONES = FRAME_BITS / 2;
  localparam logic [FRAME_BITS-1:0] SYNC_PAT =
    {{(FRAME_BITS - ONES){1'b0}}, {ONES{1'b1}}};

  logic [FRAME_BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (mode_d_i == ST_OFF) begin
      sh_q <= '0;
    end else if (at_last_i) begin
      // sent LSB first: start 1, word, stop 0
      sh_q <= (mode_d_i == ST_DATA) ? {1'b0, word_i, 1'b1} : SYNC_PAT;
    end else begin
      sh_q <= {1'b0, sh_q[FRAME_BITS-1:1]};
    end
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/framed_serial_tx.sv
module framed_serial_tx
  import ftx_pkg::*;
#(
  parameter int DATA_W          = 10,
  parameter int MIN_SYNC_FRAMES = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              edge_sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pwrdn_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic              lock_i,
  output logic              bit_o,
  output logic              oe_o
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CW = $clog2(FRAME_BITS);

  logic [DATA_W-1:0] word;
  tx_mode_e          mode, mode_d;
  logic              at_last;
  logic [CW-1:0]     cnt;
  logic              sh_bit;

  ftx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_clk_i  (ref_clk_i),
    .edge_sel_i (edge_sel_i),
    .data_i     (data_i),
    .word_o     (word)
  );

  ftx_ctrl #(.FRAME_BITS(FRAME_BITS), .MIN_SYNC_FRAMES(MIN_SYNC_FRAMES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_i     (lock_i),
    .pwrdn_i    (pwrdn_i),
    .sync_req_i (sync_a_i | sync_b_i),
    .mode_o     (mode),
    .mode_d_o   (mode_d),
    .at_last_o  (at_last),
    .cnt_o      (cnt)
  );

  ftx_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .at_last_i (at_last),
    .mode_d_i  (mode_d),
    .word_i    (word),
    .bit_o     (sh_bit)
  );

  // enable gated by live inputs so the line floats in the same cycle
  assign oe_o  = (mode != ST_OFF) & lock_i & ~pwrdn_i;
  assign bit_o = oe_o & sh_bit;

  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o && (mode == ST_DATA) && (cnt == '0) |-> bit_o); // R3
  AST_STOP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o && (cnt == CW'(FRAME_BITS - 1)) |-> !bit_o); // R3
  AST_SYNC_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o && (mode == ST_SYNC) && (cnt < CW'(FRAME_BITS / 2)) |-> bit_o); // R4
endmodule

// File: tb/sim_framed_serial_tx.sv
module sim_framed_serial_tx;
  localparam int MIN = 1024;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_clk_i = 1'b0, edge_sel_i = 1'b0, pwrdn_i = 1'b0;
  logic sync_a_i = 1'b0, sync_b_i = 1'b0, lock_i = 1'b0;
  logic [9:0] data_i = '0;
  logic bit_o, oe_o;

  always #10 clk = ~clk;

  framed_serial_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_clk_i(ref_clk_i), .edge_sel_i(edge_sel_i),
    .data_i(data_i), .pwrdn_i(pwrdn_i), .sync_a_i(sync_a_i), .sync_b_i(sync_b_i),
    .lock_i(lock_i), .bit_o(bit_o), .oe_o(oe_o)
  );

  int n_chk = 0, n_fail = 0;
  int ph = 0;
  int m_st = 0, m_scnt = 0;
  int sync_run = 0, last_run = -1;
  bit aborted = 1'b0;
  logic want_lock = 1'b0, want_pwrdn = 1'b0, want_edge = 1'b0;
  logic want_sa = 1'b0, want_sb = 1'b0;
  logic [9:0] w_a = '0, w_b = '0;
  logic [11:0] bits = '0;
  logic [11:0] expq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic boundary();
    logic [9:0] capw;
    logic [11:0] expf;
    string tag;
    expf = expq.pop_front();
    if (m_st != 0 && !aborted) begin
      if (m_st == 1) tag = "R4";
      else if (edge_sel_i) tag = "R2";
      else tag = "R3 R9";
      chk(bits == expf, tag, {20'd0, bits}, {20'd0, expf});
      if (bits == 12'h03F) sync_run++;
      else begin
        if (sync_run > 0) last_run = sync_run;
        sync_run = 0;
      end
    end
    capw = edge_sel_i ? w_b : w_a;
    edge_sel_i = want_edge; lock_i = want_lock; pwrdn_i = want_pwrdn;
    sync_a_i = want_sa; sync_b_i = want_sb;
    // frame-level model of the mode sequencing requirements
    if (!lock_i || pwrdn_i) begin m_st = 0; m_scnt = 0; end
    else if (m_st == 0) begin m_st = 1; m_scnt = 0; end
    else if (m_st == 1) begin
      if (m_scnt >= MIN - 1 && !(sync_a_i || sync_b_i)) m_st = 2;
      else if (m_scnt < MIN - 1) m_scnt++;
    end else if (sync_a_i || sync_b_i) begin m_st = 1; m_scnt = MIN - 1; end
    expq.push_back(m_st == 2 ? {1'b0, capw, 1'b1} : (m_st == 1 ? 12'h03F : 12'h000));
    aborted = 1'b0;
    bits = '0;
  endtask

  task automatic drive();
    if (ph == 0) begin w_a = 10'($urandom); data_i = w_a; end
    if (ph == 6) begin w_b = 10'($urandom); data_i = w_b; end
    ref_clk_i = (ph >= 2 && ph <= 7);
  endtask

  task automatic step();
    logic exp_oe;
    @(negedge clk);
    ph = (ph == 11) ? 0 : ph + 1;
    exp_oe = (m_st != 0) && lock_i && !pwrdn_i;
    chk(oe_o == exp_oe, !lock_i ? "R7" : (pwrdn_i ? "R8" : "R5"),
        {31'd0, oe_o}, {31'd0, exp_oe});
    if (!exp_oe) chk(bit_o == 1'b0, "R7", {31'd0, bit_o}, 32'd0);
    if (oe_o) bits[ph] = bit_o;
    if (ph == 11) boundary();
    drive();
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n * 12; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(oe_o == 1'b0, "R1", {31'd0, oe_o}, 32'd0);
    chk(bit_o == 1'b0, "R1", {31'd0, bit_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    ph = 0;
    expq.push_back(12'h000);
    drive();
    run_frames(3);

    want_lock = 1'b1; last_run = -1;
    run_frames(MIN + 30);
    chk(last_run == MIN, "R5", last_run, MIN);

    want_edge = 1'b1;
    run_frames(20);

    want_sa = 1'b1; last_run = -1;
    run_frames(5);
    want_sa = 1'b0;
    run_frames(10);
    chk(last_run == 5, "R10", last_run, 5);

    want_sb = 1'b1; last_run = -1;
    run_frames(5);
    want_sb = 1'b0;
    run_frames(10);
    chk(last_run == 5, "R6", last_run, 5);

    while (ph != 4) step();
    pwrdn_i = 1'b1; want_pwrdn = 1'b1; aborted = 1'b1;
    step();
    chk(oe_o == 1'b0, "R8", {31'd0, oe_o}, 32'd0);
    run_frames(3);
    want_pwrdn = 1'b0; want_sa = 1'b1; last_run = -1;
    run_frames(1100);
    want_sa = 1'b0;
    run_frames(10);
    chk(last_run == 1100, "R6", last_run, 1100);

    want_edge = 1'b0; want_lock = 1'b0;
    run_frames(3);
    want_lock = 1'b1; last_run = -1;
    run_frames(MIN + 15);
    chk(last_run == MIN, "R7", last_run, MIN);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule